// File: doc/BRIEF.md
# Single-Byte SPI Master with Independent Launch and Sample Phases

This block shifts one byte out on MOSI and one byte in from MISO while driving the serial clock and an active-low chip select. The clock polarity is a separate setting. The SCLK edge that launches outgoing data and the SCLK edge that captures incoming data are chosen by two separate phase bits. Each phase bit selects odd-numbered or even-numbered edges, counting by position in the transfer. Whether an edge rises or falls plays no part in the choice. Any polarity can therefore be paired with any launch/sample relationship a slave needs.

A host first writes a configuration word. It then pulses `start` with a byte to send and waits for `busy` to drop, at which point `rx_byte` holds the byte received. The SCLK half-period is counted in ticks of either the system clock or an external slow tick strobe. A preload of zero always uses the system clock, whatever the source setting.

Top module: `spi_split_phase_master`

## Requirements
- R1: After reset, cs_n is 1, busy is 0, sclk is 0, mosi is 0 and rx_byte is 0. The configuration resets to receive phase 1, with polarity, transmit phase, source select and preload all 0.
- R2: The configuration word `cfg_wdata` is laid out as follows: bit 0 is the transmit phase, bit 1 the receive phase, bit 2 the polarity, bit 3 the slow-source select and bits [11:4] the preload. With polarity 0, sclk idles low and the first edge of a transfer rises. With polarity 1, sclk idles high and the first edge falls.
- R3: With receive phase 0, MISO is captured on edges 1, 3, 5 … 15. With receive phase 1, it is captured on edges 2, 4 … 16. Edges are numbered by position in the transfer.
- R4: With transmit phase 0, the MSB is on MOSI when cs_n falls and the next bits change on even edges. With transmit phase 1, the MSB is first driven on edge 1 and the next bits change on odd edges.
- R5: Every transfer has exactly 16 sclk edges and moves exactly 8 bits each way, MSB first, for all eight combinations of polarity and the two phase bits.
- R6: The sclk half-period is preload+1 ticks. cs_n falls one half-period before edge 1 and rises one half-period after edge 16. With the system clock as source, busy stays high for 17×(preload+1) cycles.
- R7: With preload 0, the source-select bit has no effect, and a transfer takes 17 system-clock cycles even when no slow tick arrives.
- R8: With source select 1 and a non-zero preload, the half-period counts pulses of `slow_tick` instead of system clocks.
- R9: While busy is high, configuration writes and further start pulses are ignored: the transfer in flight, the idle level afterwards and the following transfer all use the earlier configuration.
- R10: A start while idle raises busy and lowers cs_n on the next cycle. busy falls in the same cycle that cs_n rises, and rx_byte already holds the new byte in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | DIV_W+4 | Configuration word (phase, polarity, source, preload) |
| slow_tick | input | 1 | Alternate slow time-base strobe, one clock wide |
| start | input | 1 | Start one transfer |
| tx_byte | input | DATA_W | Byte to send, taken with start |
| busy | output | 1 | Transfer in progress |
| rx_byte | output | DATA_W | Byte last received |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| cs_n | output | 1 | Active-low chip select |
| miso | input | 1 | Serial data in |

## Verification
busy and cs_n must respond on the first clock after an accepted start. rx_byte must be valid on the very cycle busy falls. With the system clock as source, busy must stay high for exactly 17×(preload+1) cycles, and a polarity change shows up on idle sclk one cycle after the write. The bench drives inputs and samples outputs on falling clock edges, so each registered result is read half a cycle after the rising edge that produced it. A monitor counts the cycles during which busy is high and pops the expected bytes and duration from the scoreboard at the first sample where busy reads low. A behavioural slave numbers the sclk edges itself and checks the idle level and the direction of the first edge against its own record of the configuration.

// File: rtl/spi_sp_pkg.sv
package spi_sp_pkg;

    typedef struct packed {
        logic slow_src;
        logic pol;
        logic rx_ph;
        logic tx_ph;
    } spi_mode_t;

    localparam int MODE_W = 4;

    localparam spi_mode_t MODE_RESET = '{slow_src: 1'b0, pol: 1'b0, rx_ph: 1'b1, tx_ph: 1'b0};

    typedef enum logic {
        SEQ_IDLE   = 1'b0,
        SEQ_ACTIVE = 1'b1
    } seq_state_t;

    // Launch: phase 1 uses odd edges, phase 0 uses even edges except the final one.
    function automatic logic launch_edge(input logic tx_ph, input logic odd, input logic last);
        return tx_ph ? odd : (!odd && !last);
    endfunction

    // Capture: phase 0 uses odd edges, phase 1 uses even edges.
    function automatic logic sample_edge(input logic rx_ph, input logic odd);
        return rx_ph ? !odd : odd;
    endfunction

endpackage

// File: rtl/spi_sp_cfg.sv
module spi_sp_cfg
    import spi_sp_pkg::*;
#(
    parameter int DIV_W = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_en,
    input  logic [DIV_W+MODE_W-1:0] wr_data,
    input  logic                    lock,
    output spi_mode_t               mode,
    output logic [DIV_W-1:0]        preload
);

    typedef struct packed {
        spi_mode_t          mode;
        logic [DIV_W-1:0]   preload;
    } cfg_t;

    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (wr_en && !lock) begin
            cfg_d.mode    = spi_mode_t'(wr_data[MODE_W-1:0]);
            cfg_d.preload = wr_data[DIV_W+MODE_W-1:MODE_W];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q.mode    <= MODE_RESET;
            cfg_q.preload <= '0;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign mode    = cfg_q.mode;
    assign preload = cfg_q.preload;

endmodule

// File: rtl/spi_sp_halfper.sv
module spi_sp_halfper #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             slow_src,
    input  logic             slow_tick,
    input  logic [DIV_W-1:0] preload,
    output logic             step
);

    typedef struct packed {
        logic [DIV_W-1:0] cnt;
    } div_t;

    div_t div_d, div_q;
    logic tick_en;

    always_comb begin
        div_d   = div_q;
        step    = 1'b0;
        tick_en = (slow_src && (preload != '0)) ? slow_tick : 1'b1;
        if (!run) begin
            div_d.cnt = '0;
        end else if (tick_en) begin
            if (div_q.cnt == preload) begin
                step      = 1'b1;
                div_d.cnt = '0;
            end else begin
                div_d.cnt = div_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_q.cnt <= '0;
        end else begin
            div_q <= div_d;
        end
    end

endmodule

// File: rtl/spi_sp_shift.sv
module spi_sp_shift
    import spi_sp_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [DATA_W-1:0] tx_data,
    input  logic              tx_ph,
    input  logic              rx_ph,
    input  logic              edge_en,
    input  logic              edge_odd,
    input  logic              edge_last,
    input  logic              done,
    input  logic              miso,
    output logic              mosi,
    output logic [DATA_W-1:0] rx_data
);

    typedef struct packed {
        logic [DATA_W-1:0] tx_sh;
        logic [DATA_W-1:0] rx_sh;
        logic [DATA_W-1:0] rx_out;
        logic              mosi;
    } sh_t;

    sh_t sh_d, sh_q;

    always_comb begin
        sh_d = sh_q;
        if (load) begin
            sh_d.rx_sh = '0;
            if (!tx_ph) begin
                sh_d.mosi  = tx_data[DATA_W-1];
                sh_d.tx_sh = tx_data << 1;
            end else begin
                sh_d.mosi  = 1'b0;
                sh_d.tx_sh = tx_data;
            end
        end else if (edge_en) begin
            if (launch_edge(tx_ph, edge_odd, edge_last)) begin
                sh_d.mosi  = sh_q.tx_sh[DATA_W-1];
                sh_d.tx_sh = sh_q.tx_sh << 1;
            end
            if (sample_edge(rx_ph, edge_odd)) begin
                sh_d.rx_sh = {sh_q.rx_sh[DATA_W-2:0], miso};
            end
        end else if (done) begin
            sh_d.rx_out = sh_q.rx_sh;
            sh_d.mosi   = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_q.tx_sh  <= '0;
            sh_q.rx_sh  <= '0;
            sh_q.rx_out <= '0;
            sh_q.mosi   <= 1'b0;
        end else begin
            sh_q <= sh_d;
        end
    end

    assign mosi    = sh_q.mosi;
    assign rx_data = sh_q.rx_out;

endmodule

// File: rtl/spi_split_phase_master.sv
module spi_split_phase_master
    import spi_sp_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int DIV_W  = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    cfg_we,
    input  logic [DIV_W+MODE_W-1:0] cfg_wdata,
    input  logic                    slow_tick,
    input  logic                    start,
    input  logic [DATA_W-1:0]       tx_byte,
    output logic                    busy,
    output logic [DATA_W-1:0]       rx_byte,
    output logic                    sclk,
    output logic                    mosi,
    output logic                    cs_n,
    input  logic                    miso
);

    localparam int EDGES = 2 * DATA_W;
    localparam int IDX_W = $clog2(EDGES + 1);

    typedef struct packed {
        seq_state_t        state;
        logic [IDX_W-1:0]  idx;
        logic              sclk;
        logic              cs_n;
    } seq_t;

    seq_t             seq_d, seq_q;
    spi_mode_t        mode;
    logic [DIV_W-1:0] preload;
    logic             step;
    logic             accept;
    logic             edge_en;
    logic             done;
    logic             edge_odd;
    logic             edge_last;
    logic             lock;

    assign busy = (seq_q.state == SEQ_ACTIVE);
    assign lock = busy | start;

    spi_sp_cfg #(.DIV_W(DIV_W)) u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (cfg_we),
        .wr_data (cfg_wdata),
        .lock    (lock),
        .mode    (mode),
        .preload (preload)
    );

    spi_sp_halfper #(.DIV_W(DIV_W)) u_div (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (busy),
        .slow_src  (mode.slow_src),
        .slow_tick (slow_tick),
        .preload   (preload),
        .step      (step)
    );

    always_comb begin
        seq_d     = seq_q;
        accept    = 1'b0;
        edge_en   = 1'b0;
        done      = 1'b0;
        edge_odd  = !seq_q.idx[0];
        edge_last = (seq_q.idx == IDX_W'(EDGES - 1));
        case (seq_q.state)
            SEQ_IDLE: begin
                seq_d.sclk = mode.pol;
                seq_d.cs_n = 1'b1;
                if (start) begin
                    accept      = 1'b1;
                    seq_d.state = SEQ_ACTIVE;
                    seq_d.cs_n  = 1'b0;
                    seq_d.idx   = '0;
                end
            end
            SEQ_ACTIVE: begin
                if (step) begin
                    if (seq_q.idx != IDX_W'(EDGES)) begin
                        edge_en    = 1'b1;
                        seq_d.sclk = ~seq_q.sclk;
                        seq_d.idx  = seq_q.idx + 1'b1;
                    end else begin
                        done        = 1'b1;
                        seq_d.state = SEQ_IDLE;
                        seq_d.cs_n  = 1'b1;
                        seq_d.idx   = '0;
                    end
                end
            end
            default: seq_d.state = SEQ_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q.state <= SEQ_IDLE;
            seq_q.idx   <= '0;
            seq_q.sclk  <= MODE_RESET.pol;
            seq_q.cs_n  <= 1'b1;
        end else begin
            seq_q <= seq_d;
        end
    end

    spi_sp_shift #(.DATA_W(DATA_W)) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (accept),
        .tx_data   (tx_byte),
        .tx_ph     (mode.tx_ph),
        .rx_ph     (mode.rx_ph),
        .edge_en   (edge_en),
        .edge_odd  (edge_odd),
        .edge_last (edge_last),
        .done      (done),
        .miso      (miso),
        .mosi      (mosi),
        .rx_data   (rx_byte)
    );

    assign sclk = seq_q.sclk;
    assign cs_n = seq_q.cs_n;

endmodule

// File: rtl/spi_sp_chk.sv
module spi_sp_chk #(
    parameter int DATA_W = 8,
    parameter int DIV_W  = 8
) (
    input logic                           clk,
    input logic                           rst_n,
    input logic                           start,
    input logic                           busy,
    input logic                           cs_n,
    input logic                           sclk,
    input logic                           mosi,
    input logic [3:0]                     mode,
    input logic [DIV_W-1:0]               preload,
    input logic                           step,
    input logic [$clog2(2*DATA_W+1)-1:0]  idx
);

    localparam int EDGES = 2 * DATA_W;

    // R10
    busy_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> (busy && !cs_n));

    // R2
    idle_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !$past(busy)) |-> (sclk == $past(mode[2])));

    // R9
    cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> ($stable(mode) && $stable(preload)));

    // R6
    sclk_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy) && !$past(step)) |-> $stable(sclk));

    // R4
    mosi_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy) && !$past(step)) |-> $stable(mosi));

    // R7
    fast_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && preload == '0) |-> step);

    // R5
    edge_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (idx <= EDGES));

endmodule

bind spi_split_phase_master spi_sp_chk #(.DATA_W(DATA_W), .DIV_W(DIV_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .busy    (busy),
    .cs_n    (cs_n),
    .sclk    (sclk),
    .mosi    (mosi),
    .mode    (mode),
    .preload (preload),
    .step    (step),
    .idx     (seq_q.idx)
);

// File: tb/spi_split_phase_master_tb.sv
module spi_split_phase_master_tb;

    localparam int CLK_PERIOD = 10;
    localparam int DATA_W     = 8;
    localparam int DIV_W      = 8;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cfg_we = 1'b0;
    logic [DIV_W+3:0]  cfg_wdata = '0;
    logic              slow_tick = 1'b0;
    logic              start = 1'b0;
    logic [DATA_W-1:0] tx_byte = '0;
    logic              busy, sclk, mosi, cs_n;
    logic [DATA_W-1:0] rx_byte;
    logic              miso = 1'b0;

    int errs = 0;
    int checks = 0;

    bit tb_pol = 1'b0, tb_txph = 1'b0, tb_rxph = 1'b1;
    bit slow_en = 1'b0;

    logic [7:0] slv_tx = '0, slv_rx = '0, slv_sh = '0;
    int  slv_edges = 0;
    bit  idle_ok = 1'b0, first_ok = 1'b0, odd_e = 1'b0;

    typedef struct {
        logic [7:0] exp_rx;
        logic [7:0] exp_slv;
        int         cyc_lo;
        int         cyc_hi;
        string      tag;
    } item_t;

    item_t sb[$];

    spi_split_phase_master #(.DATA_W(DATA_W), .DIV_W(DIV_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .slow_tick(slow_tick), .start(start), .tx_byte(tx_byte), .busy(busy),
        .rx_byte(rx_byte), .sclk(sclk), .mosi(mosi), .cs_n(cs_n), .miso(miso)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Slow time base: one-clock strobe every fourth cycle when enabled.
    initial begin
        int n = 0;
        forever begin
            @(negedge clk);
            n++;
            slow_tick = slow_en && (n % 4 == 0);
        end
    end

    // Behavioural slave: numbers edges by position, uses the bench's view of the config.
    always @(negedge cs_n) begin
        slv_edges = 0;
        slv_rx    = '0;
        slv_sh    = slv_tx;
        first_ok  = 1'b0;
        #1;
        idle_ok = (sclk === tb_pol);
        if (!tb_rxph) begin
            miso   = slv_sh[7];
            slv_sh = slv_sh << 1;
        end
    end

    always @(sclk) begin
        if (cs_n === 1'b0) begin
            slv_edges++;
            if (slv_edges == 1) first_ok = (sclk === ~tb_pol);
            odd_e = (slv_edges % 2 == 1);
            if (odd_e == !tb_txph) slv_rx = {slv_rx[6:0], mosi};
            if (odd_e == tb_rxph) begin
                miso   = slv_sh[7];
                slv_sh = slv_sh << 1;
            end
        end
    end

    // Monitor: pops an expectation at the first sample where busy reads low.
    initial begin
        int  cyc = 0;
        bit  prev = 1'b0;
        item_t it;
        forever begin
            @(negedge clk);
            if (busy === 1'b1) begin
                cyc++;
            end else if (prev) begin
                if (sb.size() == 0) begin
                    check(1'b0, "R9", "unexpected transfer", 1, 0);
                end else begin
                    it = sb.pop_front();
                    check(rx_byte === it.exp_rx, "R3", {it.tag, " rx_byte"}, rx_byte, it.exp_rx);
                    check(slv_rx === it.exp_slv, "R4", {it.tag, " slave capture"}, slv_rx, it.exp_slv);
                    check(slv_edges == 16, "R5", {it.tag, " edge count"}, slv_edges, 16);
                    check(idle_ok, "R2", {it.tag, " idle level"}, idle_ok, 1);
                    check(first_ok, "R2", {it.tag, " first edge direction"}, first_ok, 1);
                    check(cs_n === 1'b1, "R10", {it.tag, " cs_n with busy low"}, cs_n, 1);
                    check(cyc >= it.cyc_lo && cyc <= it.cyc_hi, "R6",
                          {it.tag, " busy cycles"}, cyc, it.cyc_lo);
                end
                cyc = 0;
            end
            prev = (busy === 1'b1);
        end
    end

    task automatic wr_raw(input logic [DIV_W+3:0] v);
        @(negedge clk);
        cfg_we    = 1'b1;
        cfg_wdata = v;
        @(negedge clk);
        cfg_we    = 1'b0;
    endtask

    task automatic set_cfg(input bit pol, input bit txph, input bit rxph,
                           input bit src, input logic [DIV_W-1:0] pre);
        wr_raw({pre, src, pol, rxph, txph});
        tb_pol  = pol;
        tb_txph = txph;
        tb_rxph = rxph;
    endtask

    // Driver: pushes the expectation, launches, waits for completion.
    task automatic xfer(input logic [7:0] tx, input logic [7:0] sv,
                        input int lo, input int hi, input string tag);
        item_t it;
        it.exp_rx  = sv;
        it.exp_slv = tx;
        it.cyc_lo  = lo;
        it.cyc_hi  = hi;
        it.tag     = tag;
        sb.push_back(it);
        slv_tx = sv;
        @(negedge clk);
        start   = 1'b1;
        tx_byte = tx;
        @(negedge clk);
        start   = 1'b0;
        check(busy === 1'b1 && cs_n === 1'b0, "R10", {tag, " busy/cs_n after start"},
              {busy, cs_n}, 2'b10);
        while (busy === 1'b1) @(negedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(cs_n === 1'b1, "R1", "cs_n", cs_n, 1);
        check(busy === 1'b0, "R1", "busy", busy, 0);
        check(sclk === 1'b0, "R1", "sclk", sclk, 0);
        check(mosi === 1'b0, "R1", "mosi", mosi, 0);
        check(rx_byte === 8'h00, "R1", "rx_byte", rx_byte, 0);

        // R1: default config (rx phase 1) with preload 0 -> 17 cycles
        xfer(8'hC5, 8'h3A, 17, 17, "R1 default config");

        // R2 R3 R4 R5 R6: all eight polarity/phase combinations, preload 1
        for (int c = 0; c < 8; c++) begin
            set_cfg(c[2], c[0], c[1], 1'b0, 8'd1);
            xfer(8'h96 ^ 8'(c * 17), 8'h5B ^ 8'(c * 29), 34, 34, $sformatf("R5 combo %0d", c));
        end

        // R6: preload 3 from system clock
        set_cfg(1'b1, 1'b0, 1'b0, 1'b0, 8'd3);
        xfer(8'h81, 8'h7E, 68, 68, "R6 preload3");

        // R7: preload 0 with slow select and no slow ticks
        slow_en = 1'b0;
        set_cfg(1'b0, 1'b1, 1'b1, 1'b1, 8'd0);
        xfer(8'hF0, 8'h0F, 17, 17, "R7 preload0 slow-select");

        // R8: slow source, preload 1, tick every 4 cycles -> about 136 cycles
        slow_en = 1'b1;
        set_cfg(1'b0, 1'b0, 1'b1, 1'b1, 8'd1);
        xfer(8'hA3, 8'h6D, 128, 140, "R8 slow source");
        slow_en = 1'b0;

        // R9: config write and second start during a transfer are ignored
        set_cfg(1'b1, 1'b1, 1'b0, 1'b0, 8'd1);
        fork
            xfer(8'h3C, 8'hA5, 34, 34, "R9 in-flight");
            begin
                repeat (6) @(negedge clk);
                wr_raw({8'd0, 1'b0, 1'b0, 1'b1, 1'b0});
                @(negedge clk);
                start   = 1'b1;
                tx_byte = 8'hFF;
                @(negedge clk);
                start   = 1'b0;
            end
        join
        @(negedge clk);
        check(sclk === 1'b1, "R9", "idle level after ignored write", sclk, 1);
        xfer(8'h12, 8'hED, 34, 34, "R9 follow-up");

        repeat (3) @(negedge clk);
        check(sb.size() == 0, "R9", "scoreboard drained", sb.size(), 0);
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errs++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

endmodule